// File: doc/BRIEF.md
# ADC Result Output Port

This block sits between a converter core and its host pins. It takes each new 16-bit conversion result, holds it, and presents it either as a parallel word on a 16-pad bus or as a serial bit stream. One static select picks the port type. The same 16 pads serve both purposes. In parallel mode they carry data. In serial mode a few of them carry the serial data, clock and frame sync, a few others are read back as configuration straps, and all the rest float.

Two options apply to the data itself. An optional coding change turns straight binary into twos complement by flipping the most significant bit. In parallel mode, an optional byte swap lets a host with an 8-bit bus fetch the word in two halves from the same byte lane. The serial port has two clocking modes. As master, it runs its own divided clock and frames each word with a sync pulse. As slave, it shifts on a host-supplied clock that is qualified by chip select. The clock polarity and the sync polarity can each be selected.

Top module: `adc_result_port`

## Requirements
- R1: With the port-type select low (parallel), padOe is all ones exactly while csN and rdN are both low, and all zeros otherwise.
- R2: In parallel mode with byteSwap low, padOut equals the held word. With byteSwap high, the held word's low byte appears on padOut[15:8] and its high byte on padOut[7:0].
- R3: With codeSel high, the result is output unchanged (straight binary). With codeSel low, only bit 15 of the result is inverted (twos complement). This applies in both parallel and serial modes.
- R4: With the port-type select high (serial), pads 0 to 7 and 11 to 15 are never enabled. Serial data leaves on pad 8. In master mode, pads 8, 9 and 10 are all enabled (padOe = 0x0700). The straps are read from padIn: bits 3:2 set the clock divide, bit 4 selects the clock source (0 master, 1 slave), bit 5 inverts the sync, and bit 6 inverts the serial clock.
- R5: In master mode, every result captured starts one frame of 16 bits, sent MSB first on pad 8. The serial clock is driven on pad 9. Data changes only while the uninverted clock is low, and it is valid at each rising edge.
- R6: In master mode, each serial clock half period lasts 2^d system clock cycles, where d is padIn[3:2]. One frame therefore keeps sync active for 32*2^d cycles.
- R7: In master mode, sync on pad 10 is active for the whole frame. With padIn[5] low, sync is active high. With padIn[5] high, it is active low. Between frames the serial clock rests at its inactive level.
- R8: padIn[6] high inverts the serial clock. It inverts the level driven on pad 9 in master mode, and it inverts the sense of the external clock in slave mode.
- R9: In slave mode, pad 8 is enabled only while csN is low. The MSB appears after csN falls. The next bit appears after each falling edge of the effective external clock on padIn[9], so the host samples on rising edges.
- R10: A result that arrives during a parallel read does not change the bus until the read ends, and it is then the word returned by the next read. A result that arrives during a master frame does not disturb that frame, and it is sent in the frame that follows.
- R11: Reset clears the held word, so a parallel read straight after reset returns 0x0000. No master frame starts until a result has been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| resultIn | input | 16 | Conversion result |
| resultValid | input | 1 | One-cycle strobe that captures resultIn |
| serPar | input | 1 | Port-type select: 0 parallel, 1 serial |
| byteSwap | input | 1 | Parallel byte swap select |
| codeSel | input | 1 | 1 straight binary, 0 twos complement |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Parallel read strobe, active low |
| padIn | input | 16 | Level seen on the pads (straps, external clock) |
| padOut | output | 16 | Level driven onto the pads |
| padOe | output | 16 | Per-pad output enable; 0 means high impedance |

## Verification
The bench tests the parallel corners. It checks reads with only one of the two strobes low, where a decoder that used OR instead of AND would drive the bus. It checks the swapped byte lanes, where a swap of nibbles or of bit order would scramble the word. It also checks a result that lands in the middle of a read, where a design without a parking register would change the data under the host. In master mode it decodes whole frames at divide ratios 1, 2 and 8, with either polarity, and compares both the word and the frame length. A wrong shift direction, an off-by-one bit count or a divider one step out shows up directly. A second result sent mid-frame catches a design that reloads the shifter early. Slave reads run with both clock senses, which exposes shifting on the wrong edge or ignoring the inversion.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

  // Fixed pad roles when the serial port is selected
  localparam int PAD_DIV_LO  = 2;
  localparam int PAD_EXT     = 4;
  localparam int PAD_INVSYNC = 5;
  localparam int PAD_INVSCLK = 6;
  localparam int PAD_SDO     = 8;
  localparam int PAD_SCLK    = 9;
  localparam int PAD_SYNC    = 10;

  // Strobes and levels from control to datapath
  typedef struct packed {
    logic takeResult;
    logic parkResult;
    logic commitPend;
    logic loadShift;
    logic shiftOut;
    logic sclkInt;
    logic syncActive;
  } portStrobes_t;

endpackage

// File: rtl/adc_port_ctrl.sv
module adc_port_ctrl
  import adc_port_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serPar,
  input  logic             csN,
  input  logic             rdN,
  input  logic             resultValid,
  input  logic             extClk,
  input  logic             invSclk,
  input  logic [DIV_W-1:0] divSel,
  input  logic             sclkPin,
  output portStrobes_t     strb,
  output logic             masterMode,
  output logic             slaveMode
);

  localparam int CNT_W  = $clog2(DATA_W);
  localparam int HALF_W = (1 << DIV_W) - 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic                   pendFlag;
  logic                   frameReq;
  logic                   busy;
  logic                   sclkInt;
  logic [HALF_W-1:0]      halfCnt;
  logic [HALF_W-1:0]      halfLast;
  logic [CNT_W-1:0]       bitCnt;
  logic [SYNC_STAGES-1:0] sclkSync;
  logic                   effPrev;
  logic                   effSclk;
  logic                   loaded;
  logic                   readActive;
  logic                   halfDone;
  logic                   masterStart;
  logic                   slaveStart;
  logic                   slaveFall;

  always_comb begin
    readActive  = !serPar && !csN && !rdN;
    masterMode  = serPar && !extClk;
    slaveMode   = serPar && extClk;
    halfLast    = HALF_W'((32'd1 << divSel) - 32'd1);
    halfDone    = busy && (halfCnt == halfLast);
    effSclk     = sclkSync[SYNC_STAGES-1] ^ invSclk;
    masterStart = masterMode && frameReq && !busy;
    slaveStart  = slaveMode && !csN && !loaded;
    slaveFall   = slaveMode && !csN && loaded && effPrev && !effSclk;

    strb.takeResult = resultValid && !readActive;
    strb.parkResult = resultValid && readActive;
    strb.commitPend = pendFlag && !readActive && !resultValid;
    strb.loadShift  = masterStart || slaveStart;
    strb.shiftOut   = (halfDone && sclkInt && (bitCnt != LAST_BIT)) || slaveFall;
    strb.sclkInt    = sclkInt;
    strb.syncActive = busy;
  end

  // Parking of a result that lands during a parallel read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendFlag <= 1'b0;
    end else if (strb.parkResult) begin
      pendFlag <= 1'b1;
    end else if (!readActive) begin
      pendFlag <= 1'b0;
    end
  end

  // Master frame request and bit timing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReq <= 1'b0;
      busy     <= 1'b0;
      sclkInt  <= 1'b0;
      halfCnt  <= '0;
      bitCnt   <= '0;
    end else if (!masterMode) begin
      frameReq <= 1'b0;
      busy     <= 1'b0;
      sclkInt  <= 1'b0;
      halfCnt  <= '0;
      bitCnt   <= '0;
    end else begin
      if (strb.takeResult || strb.commitPend) begin
        frameReq <= 1'b1;
      end else if (masterStart) begin
        frameReq <= 1'b0;
      end

      if (masterStart) begin
        busy    <= 1'b1;
        sclkInt <= 1'b0;
        halfCnt <= '0;
        bitCnt  <= '0;
      end else if (busy) begin
        if (halfDone) begin
          halfCnt <= '0;
          sclkInt <= !sclkInt;
          if (sclkInt) begin
            if (bitCnt == LAST_BIT) begin
              busy <= 1'b0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end
    end
  end

  // External clock synchronizer and slave framing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      effPrev  <= 1'b0;
      loaded   <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkPin};
      effPrev  <= effSclk;
      if (!slaveMode || csN) begin
        loaded <= 1'b0;
      end else if (slaveStart) begin
        loaded <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_port_dp.sv
module adc_port_dp
  import adc_port_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobes_t      strb,
  input  logic [DATA_W-1:0] resultIn,
  input  logic              codeSel,
  input  logic              byteSwap,
  input  logic              serPar,
  input  logic              masterMode,
  input  logic              slaveMode,
  input  logic              csN,
  input  logic              rdN,
  input  logic              invSync,
  input  logic              invSclk,
  output logic [DATA_W-1:0] padOut,
  output logic [DATA_W-1:0] padOe
);

  localparam int LANE_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] codedIn;
  logic [DATA_W-1:0] holdWord;
  logic [DATA_W-1:0] pendWord;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] swapWord;
  logic [DATA_W-1:0] parWord;

  assign codedIn = codeSel ? resultIn : (resultIn ^ MSB_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      pendWord <= '0;
      shiftReg <= '0;
    end else begin
      if (strb.takeResult) begin
        holdWord <= codedIn;
      end else if (strb.commitPend) begin
        holdWord <= pendWord;
      end
      if (strb.parkResult) begin
        pendWord <= codedIn;
      end
      if (strb.loadShift) begin
        shiftReg <= holdWord;
      end else if (strb.shiftOut) begin
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      end
    end
  end

  // Byte lanes exchanged for a narrow host
  for (genvar lane = 0; lane < 2; lane++) begin : g_swap
    assign swapWord[lane*LANE_W +: LANE_W] = holdWord[(1-lane)*LANE_W +: LANE_W];
  end

  assign parWord = byteSwap ? swapWord : holdWord;

  always_comb begin
    padOut = '0;
    padOe  = '0;
    if (!serPar) begin
      padOut = parWord;
      if (!csN && !rdN) begin
        padOe = '1;
      end
    end else begin
      padOut[PAD_SDO]  = shiftReg[DATA_W-1];
      padOut[PAD_SCLK] = strb.sclkInt ^ invSclk;
      padOut[PAD_SYNC] = strb.syncActive ^ invSync;
      if (masterMode) begin
        padOe[PAD_SDO]  = 1'b1;
        padOe[PAD_SCLK] = 1'b1;
        padOe[PAD_SYNC] = 1'b1;
      end else if (slaveMode && !csN) begin
        padOe[PAD_SDO] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
  import adc_port_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] resultIn,
  input  logic              resultValid,
  input  logic              serPar,
  input  logic              byteSwap,
  input  logic              codeSel,
  input  logic              csN,
  input  logic              rdN,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] padOut,
  output logic [DATA_W-1:0] padOe
);

  portStrobes_t strb;
  logic         masterMode;
  logic         slaveMode;

  adc_port_ctrl #(
    .DATA_W     (DATA_W),
    .DIV_W      (DIV_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .serPar     (serPar),
    .csN        (csN),
    .rdN        (rdN),
    .resultValid(resultValid),
    .extClk     (padIn[PAD_EXT]),
    .invSclk    (padIn[PAD_INVSCLK]),
    .divSel     (padIn[PAD_DIV_LO +: DIV_W]),
    .sclkPin    (padIn[PAD_SCLK]),
    .strb       (strb),
    .masterMode (masterMode),
    .slaveMode  (slaveMode)
  );

  adc_port_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .resultIn  (resultIn),
    .codeSel   (codeSel),
    .byteSwap  (byteSwap),
    .serPar    (serPar),
    .masterMode(masterMode),
    .slaveMode (slaveMode),
    .csN       (csN),
    .rdN       (rdN),
    .invSync   (padIn[PAD_INVSYNC]),
    .invSclk   (padIn[PAD_INVSCLK]),
    .padOut    (padOut),
    .padOe     (padOe)
  );

endmodule

// File: rtl/adc_result_port_chk.sv
module adc_result_port_chk
  import adc_port_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              serPar,
  input logic              csN,
  input logic              rdN,
  input logic [DATA_W-1:0] padIn,
  input logic [DATA_W-1:0] padOut,
  input logic [DATA_W-1:0] padOe
);

  logic armed;
  logic masterM;
  logic slaveM;
  logic rdAct;
  logic sclkLvl;
  logic syncLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assign masterM = serPar && !padIn[PAD_EXT];
  assign slaveM  = serPar && padIn[PAD_EXT];
  assign rdAct   = !serPar && !csN && !rdN;
  assign sclkLvl = padOut[PAD_SCLK] ^ padIn[PAD_INVSCLK];
  assign syncLvl = padOut[PAD_SYNC] ^ padIn[PAD_INVSYNC];

  // R1
  par_read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAct |-> (padOe == '1));

  // R1
  par_idle_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!serPar && !rdAct) |-> (padOe == '0));

  // R4
  ser_low_pads_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    serPar |-> (padOe[7:0] == '0));

  // R5
  sdo_moves_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && masterM && $past(masterM) && syncLvl && $past(syncLvl)
     && (padOut[PAD_SDO] != $past(padOut[PAD_SDO]))) |-> !sclkLvl);

  // R7
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterM && !syncLvl) |-> !sclkLvl);

  // R9
  slave_deselect_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slaveM && csN) |-> (padOe == '0));

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && rdAct && $past(rdAct)) |-> $stable(padOut));

endmodule

bind adc_result_port adc_result_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .serPar(serPar),
  .csN   (csN),
  .rdN   (rdN),
  .padIn (padIn),
  .padOut(padOut),
  .padOe (padOe)
);

// File: tb/adc_result_port_tb.sv
`timescale 1ns/1ps
module adc_result_port_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] resultIn;
  logic        resultValid;
  logic        serPar;
  logic        byteSwap;
  logic        codeSel;
  logic        csN;
  logic        rdN;
  logic [15:0] padDrv;
  logic [15:0] padOut;
  logic [15:0] padOe;

  int          nChk = 0;
  int          nFail = 0;
  bit          finished = 1'b0;
  bit          monEn = 1'b0;
  bit          inFrame = 1'b0;
  bit          sclkPrev = 1'b0;
  logic [15:0] monBits;
  int          monNb;
  int          monLen;
  logic [15:0] sbq[$];

  always #2.5 clk = ~clk;

  adc_result_port u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .resultIn   (resultIn),
    .resultValid(resultValid),
    .serPar     (serPar),
    .byteSwap   (byteSwap),
    .codeSel    (codeSel),
    .csN        (csN),
    .rdN        (rdN),
    .padIn      (padDrv),
    .padOut     (padOut),
    .padOe      (padOe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic popCmp(input string req, input logic [15:0] act);
    logic [15:0] exp;
    if (sbq.size() == 0) begin
      chk(1'b0, req, {16'h0, act}, 32'hDEAD);
    end else begin
      exp = sbq.pop_front();
      chk(act == exp, req, {16'h0, act}, {16'h0, exp});
    end
  endtask

  // Driver: capture a result and queue its expected coded value
  task automatic sendResult(input logic [15:0] raw, input bit push);
    @(negedge clk); #1;
    resultIn    = raw;
    resultValid = 1'b1;
    if (push) sbq.push_back(codeSel ? raw : (raw ^ 16'h8000));
    @(negedge clk); #1;
    resultValid = 1'b0;
  endtask

  task automatic readPar(input string req);
    @(negedge clk); #1;
    csN = 1'b0;
    rdN = 1'b0;
    @(negedge clk);
    chk(padOe == 16'hFFFF, "R1 read enables bus", {16'h0, padOe}, 32'hFFFF);
    popCmp(req, padOut);
    #1;
    csN = 1'b1;
    rdN = 1'b1;
    @(negedge clk);
    chk(padOe == 16'h0, "R1 bus floats after read", {16'h0, padOe}, 32'h0);
  endtask

  task automatic waitFrames();
    while (sbq.size() != 0 || inFrame) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic slaveRead(input string req);
    logic [15:0] got;
    got = '0;
    @(negedge clk); #1;
    csN = 1'b0;
    repeat (3) @(negedge clk);
    chk(padOe == 16'h0100, "R9 sdo enabled under select", {16'h0, padOe}, 32'h0100);
    for (int i = 0; i < 16; i++) begin
      got = {got[14:0], padOut[8]};
      #1 padDrv[9] = 1'b1 ^ padDrv[6];
      repeat (4) @(negedge clk);
      #1 padDrv[9] = 1'b0 ^ padDrv[6];
      repeat (4) @(negedge clk);
    end
    popCmp(req, got);
    #1 csN = 1'b1;
    repeat (2) @(negedge clk);
    chk(padOe == 16'h0, "R9 sdo floats when deselected", {16'h0, padOe}, 32'h0);
  endtask

  // Monitor: decode master frames from the pads
  always @(negedge clk) begin
    if (monEn) begin
      logic syncNow;
      logic sclkNow;
      syncNow = padOut[10] ^ padDrv[5];
      sclkNow = padOut[9] ^ padDrv[6];
      if (syncNow) begin
        if (!inFrame) begin
          inFrame  = 1'b1;
          monBits  = '0;
          monNb    = 0;
          monLen   = 0;
          sclkPrev = 1'b0;
        end
        monLen++;
        if (sclkNow && !sclkPrev) begin
          monBits = {monBits[14:0], padOut[8]};
          monNb++;
        end
      end else if (inFrame) begin
        inFrame = 1'b0;
        popCmp("R5 master frame word", monBits);
        chk(monNb == 16, "R5 rising edges per frame", monNb, 16);
        chk(monLen == (32 << padDrv[3:2]), "R6 frame length", monLen, 32 << padDrv[3:2]);
      end
      sclkPrev = sclkNow;
    end
  end

  initial begin
    rstN        = 1'b0;
    resultIn    = '0;
    resultValid = 1'b0;
    serPar      = 1'b0;
    byteSwap    = 1'b0;
    codeSel     = 1'b1;
    csN         = 1'b1;
    rdN         = 1'b1;
    padDrv      = '0;
    repeat (3) @(negedge clk);
    chk(padOe == 16'h0, "R11 pads float in reset", {16'h0, padOe}, 32'h0);
    #1 rstN = 1'b1;
    @(negedge clk);

    // R11: held word cleared
    sbq.push_back(16'h0000);
    readPar("R11 read after reset");

    // R1: only one strobe low
    #1 csN = 1'b0; rdN = 1'b1;
    @(negedge clk);
    chk(padOe == 16'h0, "R1 csN alone", {16'h0, padOe}, 32'h0);
    #1 csN = 1'b1; rdN = 1'b0;
    @(negedge clk);
    chk(padOe == 16'h0, "R1 rdN alone", {16'h0, padOe}, 32'h0);
    #1 rdN = 1'b1;

    // R2 / R3 parallel data
    sendResult(16'h1234, 1'b1);
    readPar("R3 straight binary");
    #1 codeSel = 1'b0;
    sendResult(16'h1234, 1'b1);
    readPar("R3 twos complement");
    #1 codeSel = 1'b1; byteSwap = 1'b1;
    sendResult(16'h12F0, 1'b0);
    sbq.push_back(16'hF012);
    readPar("R2 bytes swapped");
    #1 byteSwap = 1'b0;

    // R10: result during a parallel read
    sendResult(16'h1111, 1'b1);
    @(negedge clk); #1;
    csN = 1'b0; rdN = 1'b0;
    sendResult(16'h2222, 1'b0);
    @(negedge clk);
    popCmp("R10 bus held during read", padOut);
    #1 csN = 1'b1; rdN = 1'b1;
    repeat (2) @(negedge clk);
    sbq.push_back(16'h2222);
    readPar("R10 parked word after read");

    // Master serial
    #1 padDrv = 16'h0000; serPar = 1'b1;
    monEn = 1'b1;
    repeat (4) @(negedge clk);
    chk(padOe == 16'h0700, "R4 master pad enables", {16'h0, padOe}, 32'h0700);
    chk(padOut[10] == 1'b0, "R7 sync idle high-active", {31'h0, padOut[10]}, 0);
    chk(!inFrame, "R11 no frame before a result", {31'h0, inFrame}, 0);

    sendResult(16'hA5C3, 1'b1);
    waitFrames();
    #1 padDrv[3:2] = 2'd1;
    sendResult(16'h8001, 1'b1);
    waitFrames();
    #1 padDrv[3:2] = 2'd3;
    sendResult(16'h7FFE, 1'b1);
    waitFrames();

    #1 padDrv[3:2] = 2'd0; padDrv[5] = 1'b1;
    repeat (3) @(negedge clk);
    chk(padOut[10] == 1'b1, "R7 sync idle low-active", {31'h0, padOut[10]}, 1);
    sendResult(16'h1357, 1'b1);
    waitFrames();

    #1 padDrv[6] = 1'b1;
    repeat (3) @(negedge clk);
    chk(padOut[9] == 1'b1, "R8 inverted sclk idle", {31'h0, padOut[9]}, 1);
    sendResult(16'hFEDC, 1'b1);
    waitFrames();

    #1 codeSel = 1'b0;
    sendResult(16'h0F0F, 1'b1);
    waitFrames();
    #1 codeSel = 1'b1; padDrv[6] = 1'b0; padDrv[5] = 1'b0; padDrv[3:2] = 2'd1;

    // R10: second result during a master frame
    sendResult(16'hC0DE, 1'b1);
    repeat (40) @(negedge clk);
    sendResult(16'h3AB9, 1'b1);
    waitFrames();
    monEn = 1'b0;

    // Slave serial
    #1 padDrv = 16'h0010;
    repeat (4) @(negedge clk);
    chk(padOe == 16'h0, "R4 slave deselected floats", {16'h0, padOe}, 32'h0);
    sendResult(16'hC3A5, 1'b1);
    slaveRead("R9 slave word");
    #1 padDrv[6] = 1'b1; padDrv[9] = 1'b1;
    repeat (4) @(negedge clk);
    sendResult(16'h5AF0, 1'b1);
    slaveRead("R8 slave inverted clock word");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

endmodule